// File: doc/BRIEF.md
# Staged Batch Dispatch Arbiter

This block sits between per-thread batch queues and per-bank command queues in a memory controller. When at least one thread reports a ready batch, the arbiter picks one of those threads and then streams that batch out, one request per clock, through a valid/ready drain handshake. The bank-queue side uses the thread number and the beat index to fetch each request and place it in the queue of the bank that request targets. When no thread has a ready batch, the arbiter waits one clock and looks again.

Each decision uses one of two policies. The first is shortest-job, which picks the ready thread with the fewest requests in flight. The second is round-robin, which resumes the search after the most recently chosen thread. Shortest-job applies only when the bank queues together hold more than a light-load threshold, and then only if some thread has a low miss rate or a pseudo-random draw succeeds. The draw succeeds with a programmable percentage. The per-thread miss-rate tracker is part of the block. It counts misses against elapsed cycles and clears itself at the end of every fixed window.

Top module: `staged_batch_arbiter`

## Requirements
- R1: During and right after reset, `drain_valid` is 0 and `batch_taken` is all zeros.
- R2: While the arbiter waits for a decision and no bit of `batch_ready` is set, no grant is made. A ready bit driven before a clock edge is granted at that edge, so `drain_valid` is 1 one clock later.
- R3: When the sum of all `bank_occ` entries is at most LIGHT_LOAD_MAX (16), the decision uses round-robin (`drain_sjf` = 0). This holds whatever the miss rates and the percentage are.
- R4: Above that load, the decision uses shortest-job (`drain_sjf` = 1) if any thread is low intensity or the random draw succeeds. Otherwise it uses round-robin.
- R5: Shortest-job grants the ready thread with the smallest `inflight` value. On a tie, the lowest thread index wins.
- R6: Round-robin searches from the thread after the last granted thread, under either policy, and wraps around. It skips threads that are not ready. After reset, the last granted thread is THREADS-1.
- R7: A grant raises exactly one bit of `batch_taken` for one clock, in the first drain beat. The drain then presents beats with `drain_idx` running from 0 to len-1, where len is the granted thread's `batch_len` sampled at the grant. The index advances only on a clock where both `drain_valid` and `drain_ready` are 1, and stays put while `drain_ready` is 0.
- R8: A write on `cfg_we` updates the percentage only when `cfg_pct` is at most 100. A larger value is ignored. The draw succeeds when the 16-bit LFSR value modulo 100 is below the percentage, so 0 never succeeds and 100 always does. The LFSR shifts left each clock and inserts bit15^bit13^bit12^bit10, starting from LFSR_SEED.
- R9: A thread is low intensity when its miss count is 0 or when misses×1000 is less than the elapsed cycles. The elapsed counter and all miss counters clear every MISS_WINDOW clocks. On the clearing clock, a miss counter loads that clock's `miss_pulse` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| batch_ready | input | THREADS | Thread has a ready batch |
| batch_len | input | THREADS×LEN_W | Request count of each thread's ready batch |
| inflight | input | THREADS×INFL_W | In-flight request count per thread |
| bank_occ | input | BANKS×OCC_W | Requests currently held in each bank queue |
| miss_pulse | input | THREADS | One miss event per thread this clock |
| cfg_we | input | 1 | Write strobe for the shortest-job percentage |
| cfg_pct | input | 7 | Percentage written, 0 to 100 |
| drain_ready | input | 1 | Bank side accepts the current beat |
| drain_valid | output | 1 | A drain beat is presented |
| drain_thread | output | TW | Thread whose batch is being drained |
| drain_idx | output | LEN_W | Position of the beat inside the batch |
| drain_sjf | output | 1 | 1 if the current batch was chosen by shortest-job |
| batch_taken | output | THREADS | One-hot pulse: this thread's batch was granted |

## Verification
The bench builds the arbiter with four threads and four banks, 3-bit batch lengths and 4-bit occupancies. These widths let occupancy sums fall on either side of the light-load threshold of 16. MISS_WINDOW is set to 400, so the bench can reach window clearing within a few hundred cycles and line up its miss pulses with the window phase. Holding the percentage at 0 or 100 makes the random draw fixed, so every policy choice can be predicted from load, intensity and the round-robin pointer. The bench also writes 101 to the percentage to check that an out-of-range value is rejected.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
    typedef enum logic {ST_PICK, ST_DRAIN} sbd_state_e;

    localparam int PCT_LIMIT   = 100;
    localparam int MPKC_SCALE  = 1000;

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/sbd_intensity.sv
module sbd_intensity #(
    parameter int THREADS = 4,
    parameter int WINDOW  = 10000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THREADS-1:0] miss_pulse,
    output logic [THREADS-1:0] low_thread
);
    import sbd_pkg::*;
    localparam int EW = $clog2(WINDOW + 1);

    logic [EW-1:0] elapsed_q;
    logic [THREADS-1:0][EW-1:0] miss_q;
    logic wrap;

    assign wrap = (elapsed_q == EW'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst)       elapsed_q <= '0;
        else if (wrap) elapsed_q <= '0;
        else           elapsed_q <= elapsed_q + 1'b1;
    end

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst)
                miss_q[t] <= '0;
            else if (wrap)
                miss_q[t] <= EW'(miss_pulse[t]);
            else if (miss_pulse[t] && (miss_q[t] != '1))
                miss_q[t] <= miss_q[t] + 1'b1;
        end
        assign low_thread[t] = (miss_q[t] == '0) ||
                               ((32'(miss_q[t]) * 32'(MPKC_SCALE)) < 32'(elapsed_q));
    end

    // R9: the window counter never reaches the window length
    a_r9_window_bound: assert property (@(posedge clk) disable iff (rst)
        elapsed_q < EW'(WINDOW));
endmodule

// File: rtl/sbd_pick.sv
module sbd_pick #(
    parameter int THREADS = 4,
    parameter int INFL_W  = 6,
    parameter int TW      = 2
) (
    input  logic [THREADS-1:0]             ready,
    input  logic [THREADS-1:0][INFL_W-1:0] inflight,
    input  logic [TW-1:0]                  last_sel,
    output logic [TW-1:0]                  sjf_sel,
    output logic [TW-1:0]                  rr_sel
);
    always_comb begin
        logic              found;
        logic [INFL_W-1:0] best;
        found   = 1'b0;
        best    = '1;
        sjf_sel = '0;
        for (int t = 0; t < THREADS; t++) begin
            if (ready[t] && (!found || (inflight[t] < best))) begin
                found   = 1'b1;
                best    = inflight[t];
                sjf_sel = TW'(t);
            end
        end
    end

    always_comb begin
        logic hit;
        int   c;
        hit    = 1'b0;
        rr_sel = last_sel;
        for (int k = 1; k <= THREADS; k++) begin
            c = (int'(last_sel) + k) % THREADS;
            if (!hit && ready[c]) begin
                hit    = 1'b1;
                rr_sel = TW'(c);
            end
        end
    end
endmodule

// File: rtl/staged_batch_arbiter.sv
module staged_batch_arbiter #(
    parameter int          THREADS        = 4,
    parameter int          BANKS          = 8,
    parameter int          LEN_W          = 4,
    parameter int          INFL_W         = 6,
    parameter int          OCC_W          = 5,
    parameter int          MISS_WINDOW    = 10000,
    parameter int          LIGHT_LOAD_MAX = 16,
    parameter int          DEFAULT_PCT    = 50,
    parameter logic [15:0] LFSR_SEED      = 16'hACE1,
    localparam int         TW             = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [THREADS-1:0]               batch_ready,
    input  logic [THREADS-1:0][LEN_W-1:0]    batch_len,
    input  logic [THREADS-1:0][INFL_W-1:0]   inflight,
    input  logic [BANKS-1:0][OCC_W-1:0]      bank_occ,
    input  logic [THREADS-1:0]               miss_pulse,
    input  logic                             cfg_we,
    input  logic [6:0]                       cfg_pct,
    input  logic                             drain_ready,
    output logic                             drain_valid,
    output logic [TW-1:0]                    drain_thread,
    output logic [LEN_W-1:0]                 drain_idx,
    output logic                             drain_sjf,
    output logic [THREADS-1:0]               batch_taken
);
    import sbd_pkg::*;
    localparam int SUMW = OCC_W + $clog2(BANKS) + 1;

    sbd_state_e         state_q;
    logic [TW-1:0]      sel_q, last_q;
    logic [LEN_W-1:0]   len_q, idx_q;
    logic               sjf_q;
    logic [THREADS-1:0] taken_q;
    logic [6:0]         pct_q;
    logic [15:0]        lfsr_q;

    logic [THREADS-1:0] low_thread;
    logic [TW-1:0]      sjf_sel, rr_sel, pick;
    logic [SUMW-1:0]    occ_sum;
    logic               light, draw, use_sjf, last_beat;

    sbd_intensity #(.THREADS(THREADS), .WINDOW(MISS_WINDOW)) u_int (
        .clk(clk), .rst(rst), .miss_pulse(miss_pulse), .low_thread(low_thread)
    );

    sbd_pick #(.THREADS(THREADS), .INFL_W(INFL_W), .TW(TW)) u_pick (
        .ready(batch_ready), .inflight(inflight), .last_sel(last_q),
        .sjf_sel(sjf_sel), .rr_sel(rr_sel)
    );

    always_comb begin
        occ_sum = '0;
        for (int b = 0; b < BANKS; b++) occ_sum = occ_sum + SUMW'(bank_occ[b]);
    end

    assign light     = (occ_sum <= SUMW'(LIGHT_LOAD_MAX));
    assign draw      = ((lfsr_q % 16'd100) < {9'd0, pct_q});
    assign use_sjf   = !light && ((|low_thread) || draw);
    assign pick      = use_sjf ? sjf_sel : rr_sel;
    assign last_beat = (len_q == '0) || (idx_q == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pct_q  <= 7'(DEFAULT_PCT);
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= lfsr_step(lfsr_q);
            if (cfg_we && (cfg_pct <= 7'(PCT_LIMIT))) pct_q <= cfg_pct;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PICK;
            sel_q   <= '0;
            last_q  <= TW'(THREADS - 1);
            len_q   <= '0;
            idx_q   <= '0;
            sjf_q   <= 1'b0;
            taken_q <= '0;
        end else begin
            taken_q <= '0;
            case (state_q)
                ST_PICK: begin
                    if (|batch_ready) begin
                        sel_q         <= pick;
                        last_q        <= pick;
                        len_q         <= batch_len[pick];
                        idx_q         <= '0;
                        sjf_q         <= use_sjf;
                        taken_q[pick] <= 1'b1;
                        state_q       <= ST_DRAIN;
                    end
                end
                default: begin
                    if (drain_ready) begin
                        if (last_beat) state_q <= ST_PICK;
                        else           idx_q   <= idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign drain_valid  = (state_q == ST_DRAIN);
    assign drain_thread = sel_q;
    assign drain_idx    = idx_q;
    assign drain_sjf    = sjf_q;
    assign batch_taken  = taken_q;

    // R7: at most one thread granted at a time
    a_r7_taken_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(batch_taken));
    // R7: the grant pulse coincides with the first beat
    a_r7_taken_first_beat: assert property (@(posedge clk) disable iff (rst)
        (|batch_taken) |-> (drain_valid && (drain_idx == '0)));
    // R7: a stalled beat is held unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_idx) && $stable(drain_thread)));
    // R2: no grant without a ready batch
    a_r2_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PICK) && !(|batch_ready)) |=> !drain_valid);
    // R6: a ready batch during a decision is always granted
    a_r6_ready_granted: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PICK) && (|batch_ready)) |=> (|batch_taken));
    // R8: the stored percentage never leaves its range
    a_r8_pct_in_range: assert property (@(posedge clk) disable iff (rst)
        pct_q <= 7'(PCT_LIMIT));
endmodule

// File: tb/sim_staged_batch_arbiter.sv
module sim_staged_batch_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int NB = 4;
    localparam int LW = 3;
    localparam int IW = 5;
    localparam int OW = 4;
    localparam int WIN = 400;

    logic clk = 0, rst = 1;
    logic [NT-1:0] batch_ready = '0;
    logic [NT-1:0][LW-1:0] batch_len = '0;
    logic [NT-1:0][IW-1:0] inflight = '0;
    logic [NB-1:0][OW-1:0] bank_occ = '0;
    logic [NT-1:0] miss_pulse = '0;
    logic cfg_we = 0;
    logic [6:0] cfg_pct = '0;
    logic drain_ready = 0;
    logic drain_valid, drain_sjf;
    logic [1:0] drain_thread;
    logic [LW-1:0] drain_idx;
    logic [NT-1:0] batch_taken;

    int checks = 0, errors = 0, cyc = 0;
    int last_m = NT - 1;
    int pct_m = 50;
    bit done = 0;

    staged_batch_arbiter #(.THREADS(NT), .BANKS(NB), .LEN_W(LW), .INFL_W(IW),
        .OCC_W(OW), .MISS_WINDOW(WIN)) u0 (
        .clk(clk), .rst(rst), .batch_ready(batch_ready), .batch_len(batch_len),
        .inflight(inflight), .bank_occ(bank_occ), .miss_pulse(miss_pulse),
        .cfg_we(cfg_we), .cfg_pct(cfg_pct), .drain_ready(drain_ready),
        .drain_valid(drain_valid), .drain_thread(drain_thread), .drain_idx(drain_idx),
        .drain_sjf(drain_sjf), .batch_taken(batch_taken));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int occ_total();
        int s = 0;
        for (int b = 0; b < NB; b++) s += int'(bank_occ[b]);
        return s;
    endfunction

    // expected decision from requirements R3..R6 (percentage kept at 0 or 100)
    task automatic model(input bit anylow, output int th, output bit sjf);
        int best = 1 << 30;
        sjf = (occ_total() > 16) && (anylow || pct_m == 100);
        th = -1;
        if (sjf) begin
            for (int t = 0; t < NT; t++)
                if (batch_ready[t] && int'(inflight[t]) < best) begin best = int'(inflight[t]); th = t; end
        end else begin
            for (int k = 1; k <= NT; k++)
                if (th < 0 && batch_ready[(last_m + k) % NT]) th = (last_m + k) % NT;
        end
    endtask

    task automatic cfg_write(input int v);
        cfg_we = 1; cfg_pct = 7'(v);
        @(negedge clk);
        cfg_we = 0;
        if (v <= 100) pct_m = v;
    endtask

    task automatic wait_phase(input int ph);
        while ((cyc % WIN) != ph) @(negedge clk);
    endtask

    task automatic pulse(input logic [NT-1:0] m);
        miss_pulse = m;
        @(negedge clk);
        miss_pulse = '0;
    endtask

    // run one decision and its drain; ready bits set by caller at a negedge
    task automatic run_batch(input bit anylow, input bit stalls, input string req);
        int th; bit sjf; int len; int b = 0;
        model(anylow, th, sjf);
        len = int'(batch_len[th]);
        @(negedge clk);
        chk(drain_valid === 1'b1, "R2", "grant one clock after ready", int'(drain_valid), 1);
        chk(int'(drain_thread) == th, req, "granted thread", int'(drain_thread), th);
        chk(drain_sjf == sjf, req, "policy sjf", int'(drain_sjf), int'(sjf));
        chk(batch_taken == NT'(1 << th), "R7", "taken pulse", int'(batch_taken), 1 << th);
        last_m = th;
        batch_ready = '0;
        while (drain_valid === 1'b1 && b <= 8) begin
            chk(int'(drain_idx) == b, "R7", "beat index", int'(drain_idx), b);
            drain_ready = stalls ? ($urandom % 3 != 0) : 1'b1;
            @(negedge clk);
            if (drain_ready) b++;
        end
        drain_ready = 0;
        chk(b == len, "R7", "beats drained", b, len);
    endtask

    task automatic set_occ(input int a, input int b, input int c, input int d);
        bank_occ[0] = OW'(a); bank_occ[1] = OW'(b); bank_occ[2] = OW'(c); bank_occ[3] = OW'(d);
    endtask

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk(drain_valid == 0 && batch_taken == 0, "R1", "outputs in reset", int'(drain_valid), 0);
        rst = 0;
        @(negedge clk);
        chk(drain_valid == 0 && batch_taken == 0, "R1", "outputs after reset", int'(batch_taken), 0);
        cfg_write(100);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(drain_valid == 0, "R2", "idle without ready", int'(drain_valid), 0);
        end
        batch_len = {3'd2, 3'd1, 3'd3, 3'd2};

        // R3: sum 16 is light -> round-robin from thread 0, thread 0 not ready
        wait_phase(2); pulse('1);
        set_occ(4, 4, 4, 4); batch_ready = 4'b0110;
        run_batch(0, 1, "R3");

        // R4/R5: sum 17, percentage 100 -> shortest-job, tie 1 vs 3 -> 1
        wait_phase(2); pulse('1);
        set_occ(5, 4, 4, 4); inflight = {5'd3, 5'd7, 5'd3, 5'd9}; batch_ready = 4'b1111;
        run_batch(0, 1, "R5");

        // R4/R6: percentage 0, all high -> round-robin after thread 1
        cfg_write(0);
        batch_ready = 4'b1001;
        run_batch(0, 0, "R6");
        // R6 wrap: last 3, ready {0,2} -> 0
        batch_ready = 4'b0101;
        run_batch(0, 1, "R6");

        // R8: 101 rejected, percentage stays 0 -> round-robin picks 1, not sjf 0
        cfg_write(101);
        inflight = {5'd2, 5'd8, 5'd9, 5'd1}; batch_ready = 4'b0011;
        run_batch(0, 0, "R8");
        // R8: 100 accepted -> shortest-job picks 3
        cfg_write(100);
        batch_ready = 4'b1100;
        run_batch(0, 0, "R8");
        cfg_write(0);

        // R9: thread 0 never missed -> low -> shortest-job under heavy load
        wait_phase(2); pulse(4'b1110);
        inflight = {5'd2, 5'd2, 5'd6, 5'd0}; batch_ready = 4'b0110;
        run_batch(1, 1, "R9");

        // R9: all missed, then window clears -> all low -> shortest-job
        wait_phase(2); pulse('1);
        wait_phase(2);
        inflight = {5'd4, 5'd4, 5'd1, 5'd5}; batch_ready = 4'b0011;
        run_batch(1, 0, "R9");

        // R3: light load overrides low intensity
        set_occ(8, 8, 0, 0); inflight = {5'd9, 5'd9, 5'd9, 5'd1}; batch_ready = 4'b0101;
        run_batch(1, 0, "R3");

        // random phase: no misses pulsed, so every thread stays low
        for (int n = 0; n < 60; n++) begin
            for (int t = 0; t < NT; t++) begin
                inflight[t] = IW'($urandom % 32);
                batch_len[t] = LW'(1 + $urandom % 4);
            end
            for (int b = 0; b < NB; b++) bank_occ[b] = OW'($urandom % 9);
            if ($urandom % 2 == 1) cfg_write(100); else cfg_write(0);
            batch_ready = NT'(1 + $urandom % 15);
            run_batch(1, 1, "R4");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule